// File: doc/BRIEF.md
# Isolated Configurable Bidirectional I/O Cell

This block is one digital I/O tile cell of a programmable fabric. It joins a fabric-side signal pair (a value the fabric wants to send out, and a value handed into the fabric) to a SoC-side signal pair (an output with its output enable, and an input). A single configuration bit held inside the cell selects whether the cell sends data toward the SoC or receives data from it.

An active-low isolation input overrides the configuration bit and forces the cell to receive. This keeps a configuration memory that has not been loaded yet from driving stray values onto the SoC side. In each direction the unused path is gated to a fixed clean level: while receiving, the SoC-side output carries the clean level; while sending, the fabric-side input carries the clean level.

The configuration bit is a scan flop. It has its own shift enable, a serial input and a serial output, so cells can be chained. A synchronous reset returns it to receive mode.

Top module: `iso_bidir_cell`

## Requirements
- R1: When `srst` is 1 at a rising clock edge, the configuration bit becomes 0 (receive), visible on `cfg_sout` after that edge.
- R2: When `srst` is 0 and `cfg_shift_en` is 1 at a rising edge, the configuration bit takes the value of `cfg_sin`, visible on `cfg_sout` after that edge.
- R3: When `srst` and `cfg_shift_en` are both 0 at a rising edge, the configuration bit keeps its value.
- R4: When `iso_n` is 0, `soc_oe` is 0 whatever the configuration bit holds.
- R5: Configuration bit 1 means send. The cell sends exactly when the configuration bit is 1 and `iso_n` is 1. It then drives `soc_oe` to 1 and `soc_out` equal to `fab_out`.
- R6: While the cell receives, `soc_out` is held at the clean level (0 with the default `GATE_LVL`) whatever `fab_out` is.
- R7: While the cell receives, `fab_in` equals `soc_in`.
- R8: While the cell sends, `fab_in` is held at the clean level (0 with the default `GATE_LVL`) whatever `soc_in` is.
- R9: When `srst` and `cfg_shift_en` are both 1 at an edge, the reset wins and the configuration bit becomes 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration flop |
| srst | input | 1 | Synchronous reset, active high, returns the cell to receive mode |
| cfg_shift_en | input | 1 | Shift enable for the configuration flop |
| cfg_sin | input | 1 | Serial configuration data in |
| cfg_sout | output | 1 | Serial configuration data out (the stored bit) |
| iso_n | input | 1 | Isolation, active low; forces receive mode |
| fab_out | input | 1 | Value from the fabric toward the SoC |
| fab_in | output | 1 | Value handed to the fabric |
| soc_in | input | 1 | Value from the SoC side |
| soc_out | output | 1 | Value driven toward the SoC side |
| soc_oe | output | 1 | Output enable toward the SoC side |

## Verification
The direction logic is tried over all four combinations of configuration bit and isolation. Only the combination with bit set and isolation released may enable the output, so an inverted or missing isolation term shows up at once. In each mode both data inputs are toggled independently: toggling the opposite-side input tells a correct gate apart from a pass-through, and toggling the same-side input tells it apart from a stuck value. Random shift sequences with reset and shift enable raised together separate reset priority, capture and hold in the flop.

// File: rtl/iso_cell_pkg.sv
package iso_cell_pkg;

   typedef enum logic {
      DIR_RECV = 1'b0,
      DIR_SEND = 1'b1
   } cell_dir_e;

   localparam int GATE_AND_STYLE = 0;
   localparam int GATE_OR_STYLE  = 1;

endpackage

// File: rtl/iso_cfg_flop.sv
module iso_cfg_flop #(
   parameter int RST_VAL = 0
) (
   input  logic clk,
   input  logic srst,
   input  logic shift_en,
   input  logic sin,
   output logic q
);
   localparam logic RST_BIT = (RST_VAL != 0);

   if (!(RST_VAL inside {0, 1})) begin : g_bad_rst
      $error("iso_cfg_flop: RST_VAL must be 0 or 1");
   end

   logic state_q;

   always_ff @(posedge clk) begin
      if (srst) begin
         state_q <= RST_BIT;
      end else if (shift_en) begin
         state_q <= sin;
      end
   end

   assign q = state_q;
endmodule

// File: rtl/iso_dir_ctrl.sv
module iso_dir_ctrl
   import iso_cell_pkg::*;
(
   input  logic      cfg_bit,
   input  logic      iso_n,
   output cell_dir_e dir
);
   always_comb begin
      if (cfg_bit && iso_n) begin
         dir = DIR_SEND;
      end else begin
         dir = DIR_RECV;
      end
   end
endmodule

// File: rtl/iso_path_gate.sv
module iso_path_gate #(
   parameter int GATE_LVL = 0
) (
   input  logic pass,
   input  logic din,
   output logic dout
);
   if (!(GATE_LVL inside {0, 1})) begin : g_bad_lvl
      $error("iso_path_gate: GATE_LVL must be 0 or 1");
   end

   if (GATE_LVL == 0) begin : g_and
      assign dout = din & pass;
   end else begin : g_or
      assign dout = din | ~pass;
   end
endmodule

// File: rtl/iso_bidir_cell.sv
module iso_bidir_cell
   import iso_cell_pkg::*;
#(
   parameter int GATE_LVL = 0,
   parameter int CFG_RST  = 0
) (
   input  logic clk,
   input  logic srst,
   input  logic cfg_shift_en,
   input  logic cfg_sin,
   output logic cfg_sout,
   input  logic iso_n,
   input  logic fab_out,
   output logic fab_in,
   input  logic soc_in,
   output logic soc_out,
   output logic soc_oe
);
   if (CFG_RST != 0) begin : g_rst_warn
      $error("iso_bidir_cell: CFG_RST must select receive mode (0)");
   end

   logic      cfg_q;
   cell_dir_e dir;
   logic      send_en;
   logic      recv_en;

   iso_cfg_flop #(
      .RST_VAL (CFG_RST)
   ) u_cfg (
      .clk      (clk),
      .srst     (srst),
      .shift_en (cfg_shift_en),
      .sin      (cfg_sin),
      .q        (cfg_q)
   );

   iso_dir_ctrl u_dir (
      .cfg_bit (cfg_q),
      .iso_n   (iso_n),
      .dir     (dir)
   );

   assign send_en = (dir == DIR_SEND);
   assign recv_en = (dir == DIR_RECV);

   iso_path_gate #(
      .GATE_LVL (GATE_LVL)
   ) u_gate_soc (
      .pass (send_en),
      .din  (fab_out),
      .dout (soc_out)
   );

   iso_path_gate #(
      .GATE_LVL (GATE_LVL)
   ) u_gate_fab (
      .pass (recv_en),
      .din  (soc_in),
      .dout (fab_in)
   );

   assign soc_oe   = send_en;
   assign cfg_sout = cfg_q;
endmodule

// File: rtl/iso_bidir_cell_chk.sv
module iso_bidir_cell_chk #(
   parameter int GATE_LVL = 0
) (
   input logic clk,
   input logic srst,
   input logic cfg_shift_en,
   input logic cfg_sin,
   input logic cfg_sout,
   input logic iso_n,
   input logic fab_out,
   input logic fab_in,
   input logic soc_in,
   input logic soc_out,
   input logic soc_oe
);
   localparam logic LVL = (GATE_LVL != 0);

   logic seen_edge;
   always_ff @(posedge clk) seen_edge <= 1'b1;

   AST_RST_CLEARS: assert property (@(posedge clk) srst |=> !cfg_sout); // R1
   AST_SHIFT_CAPTURE: assert property (@(posedge clk) disable iff (srst)
      (cfg_shift_en && seen_edge) |=> (cfg_sout == $past(cfg_sin))); // R2
   AST_HOLD: assert property (@(posedge clk) disable iff (srst)
      (!cfg_shift_en && seen_edge) |=> $stable(cfg_sout)); // R3
   AST_ISO_FORCES_RECV: assert property (@(posedge clk) disable iff (srst)
      !iso_n |-> !soc_oe); // R4
   AST_OE_NEEDS_CFG: assert property (@(posedge clk) disable iff (srst)
      soc_oe |-> (cfg_sout && soc_out == fab_out)); // R5
   AST_SOC_OUT_CLEAN: assert property (@(posedge clk) disable iff (srst)
      !soc_oe |-> (soc_out == LVL)); // R6
   AST_FAB_IN_PASS: assert property (@(posedge clk) disable iff (srst)
      !soc_oe |-> (fab_in == soc_in)); // R7
   AST_FAB_IN_CLEAN: assert property (@(posedge clk) disable iff (srst)
      soc_oe |-> (fab_in == LVL)); // R8
   AST_RST_PRIORITY: assert property (@(posedge clk)
      (srst && cfg_shift_en) |=> !cfg_sout); // R9
endmodule

bind iso_bidir_cell iso_bidir_cell_chk #(
   .GATE_LVL (GATE_LVL)
) u_chk (
   .clk          (clk),
   .srst         (srst),
   .cfg_shift_en (cfg_shift_en),
   .cfg_sin      (cfg_sin),
   .cfg_sout     (cfg_sout),
   .iso_n        (iso_n),
   .fab_out      (fab_out),
   .fab_in       (fab_in),
   .soc_in       (soc_in),
   .soc_out      (soc_out),
   .soc_oe       (soc_oe)
);

// File: tb/sim_iso_bidir_cell.sv
`timescale 1ns/1ps
module sim_iso_bidir_cell;
   logic clk = 1'b0;
   logic srst, cfg_shift_en, cfg_sin, iso_n, fab_out, soc_in;
   logic cfg_sout, fab_in, soc_out, soc_oe;

   int n_chk  = 0;
   int n_fail = 0;
   logic mdl_cfg;

   always #5 clk = ~clk;

   iso_bidir_cell u0 (
      .clk          (clk),
      .srst         (srst),
      .cfg_shift_en (cfg_shift_en),
      .cfg_sin      (cfg_sin),
      .cfg_sout     (cfg_sout),
      .iso_n        (iso_n),
      .fab_out      (fab_out),
      .fab_in       (fab_in),
      .soc_in       (soc_in),
      .soc_out      (soc_out),
      .soc_oe       (soc_oe)
   );

   function automatic logic exp_send(input logic c, input logic iso);
      return c & iso;
   endfunction

   function automatic logic exp_next(input logic c, input logic rst,
                                     input logic en, input logic d);
      if (rst) return 1'b0;
      if (en)  return d;
      return c;
   endfunction

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   // R4 R5 R6 R7 R8: output checks against the model state
   task automatic check_outputs();
      logic s;
      s = exp_send(mdl_cfg, iso_n);
      chk("R1/R2/R3 cfg_sout", cfg_sout, mdl_cfg);
      chk(iso_n ? "R5 soc_oe" : "R4 soc_oe", soc_oe, s);
      chk(s ? "R5 soc_out" : "R6 soc_out", soc_out, s ? fab_out : 1'b0);
      chk(s ? "R8 fab_in" : "R7 fab_in", fab_in, s ? 1'b0 : soc_in);
   endtask

   task automatic apply(input logic rst, input logic en, input logic d,
                        input logic iso, input logic fo, input logic si);
      @(negedge clk);
      srst = rst; cfg_shift_en = en; cfg_sin = d;
      iso_n = iso; fab_out = fo; soc_in = si;
      #1;
      check_outputs();
      @(posedge clk);
      mdl_cfg = exp_next(mdl_cfg, rst, en, d);
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      int unsigned seed;
      srst = 1'b1; cfg_shift_en = 1'b0; cfg_sin = 1'b0;
      iso_n = 1'b0; fab_out = 1'b0; soc_in = 1'b0;
      mdl_cfg = 1'b0;
      @(posedge clk);
      @(negedge clk);
      // R1: reset state is receive
      chk("R1 reset cfg", cfg_sout, 1'b0);
      chk("R1 reset oe", soc_oe, 1'b0);

      // R2: load 1, then R3 hold with enable low
      apply(0, 1, 1, 1, 0, 0);
      apply(0, 0, 0, 1, 1, 1);  // R5 send, R8 soc_in ignored
      apply(0, 0, 0, 1, 0, 1);
      apply(0, 0, 0, 0, 1, 1);  // R4 isolation forces receive, R7
      apply(0, 0, 0, 0, 1, 0);  // R6 fab_out ignored
      // R9: reset wins over shift of 1
      apply(1, 1, 1, 1, 1, 1);
      apply(0, 0, 1, 1, 1, 1);
      chk("R9 reset priority", cfg_sout, 1'b0);
      // R2 shift 0 after 1
      apply(0, 1, 1, 1, 0, 0);
      apply(0, 1, 0, 1, 1, 0);
      apply(0, 0, 1, 1, 1, 1);

      seed = 32'd1234;
      void'($urandom(seed));
      for (int i = 0; i < 2000; i++) begin
         logic [5:0] r;
         r = 6'($urandom());
         apply(r[0] & r[1] & r[2], r[3] | r[4], r[5],
               ($urandom() % 5) != 0, 1'($urandom()), 1'($urandom()));
      end

      @(negedge clk);
      check_outputs();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule